// File: doc/BRIEF.md
# Multi-cycle stored-program CPU

A small byte-wide processor that runs a fetch-execute loop from one memory holding both its program and its data. Each instruction is 16 bits and sits in two consecutive bytes. The high byte is at the lower address. The processor keeps a program pointer, a captured instruction byte and sixteen 8-bit general registers. It executes bitwise and arithmetic register operations, a signed-amount shift, loads, stores, a branch-if-zero and a halt.

The memory sits outside the block. It is a synchronous byte array: the address presented in one cycle returns its data on `mem_rdata_i` in the next cycle, and a write is committed on the clock edge that ends the cycle in which `mem_we_o` is high. A fetch takes two cycles. Register operations, stores, branches and halt then spend one execute cycle. A load spends one more cycle to receive its data. After a halt the block raises `halted_o` and stops touching memory.

Opcode field: bits 15:12. Register fields: A = bits 11:8, B = bits 7:4, C = bits 3:0. Address field: bits 7:0.

Top module: `stored_prog_cpu`

## Requirements
- R1: While `rst_ni` is low, `mem_addr_o` is 0 and `mem_we_o` and `halted_o` are 0. On release, the first fetch is from address 0 and all sixteen registers read as 0.
- R2: A fetch drives the pointer address p for one cycle and then p+1 for the next cycle. The byte at p becomes instruction bits 15:8 and the byte at p+1 becomes bits 7:0. The pointer then holds p+2, wrapping modulo 256, and the execute cycle drives that value on `mem_addr_o`.
- R3: Opcodes 1001 (AND), 1000 (OR), 0111 (XOR) and 0110 (ADD, modulo 256) combine register A with register B and write the result to register C. The whole instruction takes 3 cycles.
- R4: Opcode 0010 writes the bitwise inverse of register A into register B.
- R5: Opcode 0001 shifts register A by the amount in register B and writes the result back to register A. The amount is read as two's complement. A non-negative amount shifts right logically and a negative amount shifts left, both filling with zeros. A magnitude of 8 or more gives 0.
- R6: Opcode 0101 drives the address field on `mem_addr_o` in its execute cycle. It writes the returned byte into register A one cycle later, so the instruction takes 4 cycles.
- R7: Opcode 0100 raises `mem_we_o` for exactly its execute cycle, with the address field on `mem_addr_o` and register A on `mem_wdata_o`. Because code and data share the memory, a store can change an instruction that is fetched later.
- R8: Opcode 0011 makes the next fetch start at the address field when register A is 0. Otherwise the next fetch starts at p+2.
- R9: Opcode 0000 raises `halted_o` from the cycle after its execute cycle, and it stays high until reset. While halted, `mem_addr_o` holds the halt address plus 2 and `mem_we_o` stays low.
- R10: Opcodes 1010 to 1111 change no register and no memory byte. Execution continues at p+2 after 3 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 8 | Memory byte address |
| mem_we_o | output | 1 | Memory write enable |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Read data for the address of the previous cycle |
| halted_o | output | 1 | High once a halt has executed |

## Verification
The bench runs three programs and compares every bus cycle against an instruction-level model. The first program clamps a stored value to 100. It runs once with a value above the limit and once with a value below it, which separates a taken branch from a fall-through and a store from no store. The second program covers every logic and arithmetic operation with bit patterns that set and clear different bits. It also tries a left shift, an over-range shift, an undefined opcode, a taken branch that skips a store, and a store that rewrites the address byte of a later load. The third program branches to the top of memory so that the pointer wraps. It also relies on the registers being cleared by reset after the earlier programs left them dirty.

// File: rtl/spc_pkg.sv
package spc_pkg;

  typedef enum logic [3:0] {
    OP_HALT   = 4'b0000,
    OP_SHIFT  = 4'b0001,
    OP_NOT    = 4'b0010,
    OP_BRANCH = 4'b0011,
    OP_STORE  = 4'b0100,
    OP_LOAD   = 4'b0101,
    OP_ADD    = 4'b0110,
    OP_XOR    = 4'b0111,
    OP_OR     = 4'b1000,
    OP_AND    = 4'b1001
  } opcode_e;

  typedef enum logic [2:0] {
    ST_FETCH_HI,
    ST_FETCH_LO,
    ST_EXEC,
    ST_MEM,
    ST_HALTED
  } state_e;

  typedef enum logic [2:0] {
    ALU_AND,
    ALU_OR,
    ALU_XOR,
    ALU_ADD,
    ALU_NOT,
    ALU_SHIFT
  } alu_op_e;

  localparam int unsigned OPC_W = 4;

endpackage

// File: rtl/spc_regfile.sv
module spc_regfile #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned REG_AW = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [REG_AW-1:0] raddr_a_i,
  input  logic [REG_AW-1:0] raddr_b_i,
  output logic [DATA_W-1:0] rdata_a_o,
  output logic [DATA_W-1:0] rdata_b_o
);
  localparam int unsigned NREGS = 1 << REG_AW;

  logic [NREGS-1:0][DATA_W-1:0] regs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_q <= '0;
    end else if (we_i) begin
      regs_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_a_o = regs_q[raddr_a_i];
  assign rdata_b_o = regs_q[raddr_b_i];
endmodule

// File: rtl/spc_alu.sv
module spc_alu import spc_pkg::*; #(
  parameter int unsigned DATA_W = 8
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] y_o
);
  logic              sh_neg;
  logic [DATA_W-1:0] sh_mag;
  logic [DATA_W-1:0] sh_res;

  // b is a two's complement amount: >=0 right, <0 left
  always_comb begin
    sh_neg = b_i[DATA_W-1];
    sh_mag = sh_neg ? (~b_i + DATA_W'(1)) : b_i;
    if (sh_mag >= DATA_W'(DATA_W))
      sh_res = '0;
    else if (sh_neg)
      sh_res = a_i << sh_mag;
    else
      sh_res = a_i >> sh_mag;
  end

  always_comb begin
    case (op_i)
      ALU_AND:   y_o = a_i & b_i;
      ALU_OR:    y_o = a_i | b_i;
      ALU_XOR:   y_o = a_i ^ b_i;
      ALU_ADD:   y_o = a_i + b_i;
      ALU_NOT:   y_o = ~a_i;
      ALU_SHIFT: y_o = sh_res;
      default:   y_o = '0;
    endcase
  end
endmodule

// File: rtl/spc_decode.sv
module spc_decode import spc_pkg::*; #(
  parameter int unsigned INSTR_W = 16,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned REG_AW  = 4
) (
  input  logic [INSTR_W-1:0] instr_i,
  output logic [REG_AW-1:0]  ra_o,
  output logic [REG_AW-1:0]  rb_o,
  output logic [REG_AW-1:0]  rd_o,
  output logic [ADDR_W-1:0]  addr_o,
  output alu_op_e            alu_op_o,
  output logic               wr_alu_o,
  output logic               load_o,
  output logic               store_o,
  output logic               branch_o,
  output logic               halt_o
);
  logic [OPC_W-1:0]  opc;
  logic [REG_AW-1:0] fld_c;

  assign opc    = instr_i[INSTR_W-1 -: OPC_W];
  assign ra_o   = instr_i[INSTR_W-OPC_W-1 -: REG_AW];
  assign rb_o   = instr_i[INSTR_W-OPC_W-REG_AW-1 -: REG_AW];
  assign fld_c  = instr_i[REG_AW-1:0];
  assign addr_o = instr_i[ADDR_W-1:0];

  always_comb begin
    alu_op_o = ALU_AND;
    wr_alu_o = 1'b0;
    load_o   = 1'b0;
    store_o  = 1'b0;
    branch_o = 1'b0;
    halt_o   = 1'b0;
    rd_o     = fld_c;
    case (opc)
      OP_AND:    begin alu_op_o = ALU_AND; wr_alu_o = 1'b1; end
      OP_OR:     begin alu_op_o = ALU_OR;  wr_alu_o = 1'b1; end
      OP_XOR:    begin alu_op_o = ALU_XOR; wr_alu_o = 1'b1; end
      OP_ADD:    begin alu_op_o = ALU_ADD; wr_alu_o = 1'b1; end
      OP_NOT:    begin alu_op_o = ALU_NOT; wr_alu_o = 1'b1; rd_o = rb_o; end
      OP_SHIFT:  begin alu_op_o = ALU_SHIFT; wr_alu_o = 1'b1; rd_o = ra_o; end
      OP_LOAD:   load_o   = 1'b1;
      OP_STORE:  store_o  = 1'b1;
      OP_BRANCH: branch_o = 1'b1;
      OP_HALT:   halt_o   = 1'b1;
      default:   ; // undefined opcodes fall through as no-ops
    endcase
  end
endmodule

// File: rtl/stored_prog_cpu.sv
module stored_prog_cpu import spc_pkg::*; #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned REG_AW = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              halted_o
);
  localparam int unsigned INSTR_W = 2 * DATA_W;

  state_e             state_q;
  logic [ADDR_W-1:0]  pc_q;
  logic [ADDR_W-1:0]  pc_inc;
  logic [DATA_W-1:0]  ir_hi_q;
  logic [DATA_W-1:0]  ir_lo_q;
  logic [INSTR_W-1:0] instr;

  logic [REG_AW-1:0]  dec_ra, dec_rb, dec_rd;
  logic [ADDR_W-1:0]  dec_addr;
  alu_op_e            dec_alu_op;
  logic               dec_wr_alu, dec_load, dec_store, dec_branch, dec_halt;

  logic [DATA_W-1:0]  opa, opb, alu_y;
  logic               rf_we;
  logic [REG_AW-1:0]  rf_waddr;
  logic [DATA_W-1:0]  rf_wdata;
  logic               in_exec, in_mem;

  assign in_exec = (state_q == ST_EXEC);
  assign in_mem  = (state_q == ST_MEM);
  assign pc_inc  = pc_q + ADDR_W'(1);

  // low byte arrives on the bus during execute; use it directly
  assign instr = in_exec ? {ir_hi_q, mem_rdata_i} : {ir_hi_q, ir_lo_q};

  spc_decode #(
    .INSTR_W(INSTR_W),
    .ADDR_W (ADDR_W),
    .REG_AW (REG_AW)
  ) i_decode (
    .instr_i (instr),
    .ra_o    (dec_ra),
    .rb_o    (dec_rb),
    .rd_o    (dec_rd),
    .addr_o  (dec_addr),
    .alu_op_o(dec_alu_op),
    .wr_alu_o(dec_wr_alu),
    .load_o  (dec_load),
    .store_o (dec_store),
    .branch_o(dec_branch),
    .halt_o  (dec_halt)
  );

  spc_regfile #(
    .DATA_W(DATA_W),
    .REG_AW(REG_AW)
  ) i_regfile (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (rf_we),
    .waddr_i  (rf_waddr),
    .wdata_i  (rf_wdata),
    .raddr_a_i(dec_ra),
    .raddr_b_i(dec_rb),
    .rdata_a_o(opa),
    .rdata_b_o(opb)
  );

  spc_alu #(
    .DATA_W(DATA_W)
  ) i_alu (
    .op_i(dec_alu_op),
    .a_i (opa),
    .b_i (opb),
    .y_o (alu_y)
  );

  assign rf_we    = (in_exec && dec_wr_alu) || in_mem;
  assign rf_waddr = in_mem ? dec_ra : dec_rd;
  assign rf_wdata = in_mem ? mem_rdata_i : alu_y;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_FETCH_HI;
      pc_q    <= '0;
      ir_hi_q <= '0;
      ir_lo_q <= '0;
    end else begin
      case (state_q)
        ST_FETCH_HI: begin
          pc_q    <= pc_inc;
          state_q <= ST_FETCH_LO;
        end
        ST_FETCH_LO: begin
          ir_hi_q <= mem_rdata_i;
          pc_q    <= pc_inc;
          state_q <= ST_EXEC;
        end
        ST_EXEC: begin
          ir_lo_q <= mem_rdata_i;
          if (dec_load)      state_q <= ST_MEM;
          else if (dec_halt) state_q <= ST_HALTED;
          else               state_q <= ST_FETCH_HI;
          if (dec_branch && (opa == '0)) pc_q <= dec_addr;
        end
        ST_MEM:  state_q <= ST_FETCH_HI;
        default: state_q <= ST_HALTED;
      endcase
    end
  end

  assign mem_addr_o  = (in_exec && (dec_load || dec_store)) ? dec_addr : pc_q;
  assign mem_we_o    = in_exec && dec_store;
  assign mem_wdata_o = opa;
  assign halted_o    = (state_q == ST_HALTED);
endmodule

// File: rtl/spc_checker.sv
module spc_checker import spc_pkg::*; #(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input state_e            state_i,
  input logic [ADDR_W-1:0] mem_addr_i,
  input logic              mem_we_i,
  input logic              halted_i
);
  AST_FETCH_NEXT_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_FETCH_HI) |=> (mem_addr_i == $past(mem_addr_i) + ADDR_W'(1))); // R2

  AST_WE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |=> !mem_we_i); // R7

  AST_WE_IN_EXEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |-> (state_i == ST_EXEC)); // R7

  AST_HALT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_i |=> halted_i); // R9

  AST_HALT_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_i |-> !mem_we_i); // R9

  AST_HALT_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_i |=> $stable(mem_addr_i)); // R9
endmodule

bind stored_prog_cpu spc_checker #(.ADDR_W(ADDR_W)) i_spc_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .state_i   (state_q),
  .mem_addr_i(mem_addr_o),
  .mem_we_i  (mem_we_o),
  .halted_i  (halted_o)
);

// File: tb/test_stored_prog_cpu.sv
module test_stored_prog_cpu;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] mem_addr, mem_wdata, mem_rdata;
  logic       mem_we, halted;
  logic [7:0] mem [256];

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  stored_prog_cpu i_stored_prog_cpu (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .mem_addr_o (mem_addr),
    .mem_we_o   (mem_we),
    .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata),
    .halted_o   (halted)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  // instruction-level reference model
  int    m_mem [256];
  int    m_reg [16];
  int    m_pc;
  bit    m_halted;
  int    q_addr[$];
  bit    q_we[$];
  int    q_wd[$];
  bit    q_h[$];
  string q_tag[$];

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic push(int a, bit we, int wd, bit h, string tag);
    q_addr.push_back(a & 255); q_we.push_back(we); q_wd.push_back(wd & 255);
    q_h.push_back(h); q_tag.push_back(tag);
  endtask

  function automatic int shift_ref(int v, int amt);
    int mag;
    if (amt >= 128) begin
      mag = 256 - amt;
      return (mag >= 8) ? 0 : ((v << mag) & 255);
    end
    return (amt >= 8) ? 0 : (v >> amt);
  endfunction

  task automatic model_step();
    int p, hi, lo, op, ra, rb, rc, nx;
    p  = m_pc;
    hi = m_mem[p];
    lo = m_mem[(p + 1) & 255];
    op = hi >> 4; ra = hi & 15; rb = lo >> 4; rc = lo & 15;
    nx = (p + 2) & 255;
    push(p, 0, 0, 0, "R2");
    push(p + 1, 0, 0, 0, "R2");
    m_pc = nx;
    case (op)
      9: begin push(nx, 0, 0, 0, "R3"); m_reg[rc] = m_reg[ra] & m_reg[rb]; end
      8: begin push(nx, 0, 0, 0, "R3"); m_reg[rc] = m_reg[ra] | m_reg[rb]; end
      7: begin push(nx, 0, 0, 0, "R3"); m_reg[rc] = m_reg[ra] ^ m_reg[rb]; end
      6: begin push(nx, 0, 0, 0, "R3"); m_reg[rc] = (m_reg[ra] + m_reg[rb]) & 255; end
      2: begin push(nx, 0, 0, 0, "R4"); m_reg[rb] = (~m_reg[ra]) & 255; end
      1: begin push(nx, 0, 0, 0, "R5"); m_reg[ra] = shift_ref(m_reg[ra], m_reg[rb]); end
      5: begin push(lo, 0, 0, 0, "R6"); push(nx, 0, 0, 0, "R6"); m_reg[ra] = m_mem[lo]; end
      4: begin push(lo, 1, m_reg[ra], 0, "R7"); m_mem[lo] = m_reg[ra]; end
      3: begin push(nx, 0, 0, 0, "R8"); if (m_reg[ra] == 0) m_pc = lo; end
      0: begin push(nx, 0, 0, 0, "R9"); m_halted = 1'b1; end
      default: push(nx, 0, 0, 0, "R10");
    endcase
  endtask

  task automatic begin_prog();
    @(negedge clk);
    rst_ni = 1'b0;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
  endtask

  task automatic poke(int a, int d);
    mem[a] = d[7:0];
  endtask

  task automatic run_prog();
    int tail;
    for (int i = 0; i < 256; i++) m_mem[i] = mem[i];
    for (int i = 0; i < 16; i++) m_reg[i] = 0;
    m_pc = 0; m_halted = 1'b0;
    q_addr.delete(); q_we.delete(); q_wd.delete(); q_h.delete(); q_tag.delete();
    repeat (2) @(negedge clk);
    chk(mem_addr == 8'h00, "R1", "reset addr", mem_addr, 0);
    chk(mem_we == 1'b0, "R1", "reset we", mem_we, 0);
    chk(halted == 1'b0, "R1", "reset halted", halted, 0);
    rst_ni = 1'b1;
    tail = 0;
    while (tail < 10) begin
      if (q_addr.size() == 0) begin
        if (m_halted) begin push(m_pc, 0, 0, 1, "R9"); tail++; end
        else model_step();
      end
      begin
        int a = q_addr.pop_front();
        bit w = q_we.pop_front();
        int d = q_wd.pop_front();
        bit h = q_h.pop_front();
        string t = q_tag.pop_front();
        chk(int'(mem_addr) == a, t, "mem_addr", mem_addr, a);
        chk(mem_we == w, t, "mem_we", mem_we, w);
        if (w) chk(int'(mem_wdata) == d, t, "mem_wdata", mem_wdata, d);
        chk(halted == h, t, "halted", halted, h);
      end
      @(negedge clk);
    end
  endtask

  task automatic load_clamp(int mark);
    begin_prog();
    poke(8'h00, 8'h53); poke(8'h01, 8'h16);
    poke(8'h02, 8'h52); poke(8'h03, 8'h17);
    poke(8'h04, 8'h51); poke(8'h05, 8'h18);
    poke(8'h06, 8'h50); poke(8'h07, 8'h19);
    poke(8'h08, 8'h20); poke(8'h09, 8'h00);
    poke(8'h0A, 8'h60); poke(8'h0B, 8'h30);
    poke(8'h0C, 8'h60); poke(8'h0D, 8'h20);
    poke(8'h0E, 8'h10); poke(8'h0F, 8'h10);
    poke(8'h10, 8'h30); poke(8'h11, 8'h14);
    poke(8'h12, 8'h42); poke(8'h13, 8'h19);
    poke(8'h14, 8'h00); poke(8'h15, 8'h00);
    poke(8'h16, 1); poke(8'h17, 100); poke(8'h18, 7); poke(8'h19, mark);
  endtask

  initial begin
    // program 1: clamp above the limit -> store taken (R8 fall-through, R7)
    load_clamp(104);
    run_prog();
    chk(mem[8'h19] == 8'd100, "R7", "clamped mark", mem[8'h19], 100);

    // program 1 again: below the limit -> branch skips store (R8)
    load_clamp(90);
    run_prog();
    chk(mem[8'h19] == 8'd90, "R8", "unclamped mark", mem[8'h19], 90);

    // program 2: operation coverage
    begin_prog();
    poke(8'h00, 8'h51); poke(8'h01, 8'h80);
    poke(8'h02, 8'h52); poke(8'h03, 8'h81);
    poke(8'h04, 8'h91); poke(8'h05, 8'h23);
    poke(8'h06, 8'h81); poke(8'h07, 8'h24);
    poke(8'h08, 8'h71); poke(8'h09, 8'h25);
    poke(8'h0A, 8'h61); poke(8'h0B, 8'h26);
    poke(8'h0C, 8'h22); poke(8'h0D, 8'h70);
    poke(8'h0E, 8'h58); poke(8'h0F, 8'h82);
    poke(8'h10, 8'h11); poke(8'h11, 8'h80);
    poke(8'h12, 8'h59); poke(8'h13, 8'h83);
    poke(8'h14, 8'h12); poke(8'h15, 8'h90);
    poke(8'h16, 8'hA3); poke(8'h17, 8'h45);
    poke(8'h18, 8'h43); poke(8'h19, 8'h90);
    poke(8'h1A, 8'h44); poke(8'h1B, 8'h91);
    poke(8'h1C, 8'h45); poke(8'h1D, 8'h92);
    poke(8'h1E, 8'h46); poke(8'h1F, 8'h93);
    poke(8'h20, 8'h47); poke(8'h21, 8'h94);
    poke(8'h22, 8'h41); poke(8'h23, 8'h95);
    poke(8'h24, 8'h42); poke(8'h25, 8'h96);
    poke(8'h26, 8'h31); poke(8'h27, 8'h40);
    poke(8'h28, 8'h40); poke(8'h29, 8'h2F);
    poke(8'h2A, 8'h30); poke(8'h2B, 8'h2E);
    poke(8'h2C, 8'h41); poke(8'h2D, 8'h98);
    poke(8'h2E, 8'h5A); poke(8'h2F, 8'h84);
    poke(8'h30, 8'h4A); poke(8'h31, 8'h97);
    poke(8'h32, 8'h00); poke(8'h33, 8'h00);
    poke(8'h80, 8'hB6); poke(8'h81, 8'h68); poke(8'h82, 8'hFE);
    poke(8'h83, 8'h09); poke(8'h84, 8'hF0); poke(8'h98, 8'hEE);
    run_prog();
    chk(mem[8'h90] == 8'h20, "R3", "AND result", mem[8'h90], 8'h20);
    chk(mem[8'h91] == 8'hFE, "R3", "OR result", mem[8'h91], 8'hFE);
    chk(mem[8'h92] == 8'hDE, "R10", "XOR result after undefined op", mem[8'h92], 8'hDE);
    chk(mem[8'h93] == 8'h1E, "R3", "ADD wrap", mem[8'h93], 8'h1E);
    chk(mem[8'h94] == 8'h97, "R4", "NOT result", mem[8'h94], 8'h97);
    chk(mem[8'h95] == 8'hD8, "R5", "left shift by -2", mem[8'h95], 8'hD8);
    chk(mem[8'h96] == 8'h00, "R5", "shift by 9", mem[8'h96], 0);
    chk(mem[8'h97] == 8'h51, "R7", "self-modified load", mem[8'h97], 8'h51);
    chk(mem[8'h98] == 8'hEE, "R8", "skipped store", mem[8'h98], 8'hEE);
    chk(halted == 1'b1, "R9", "halted at end", halted, 1);

    // program 3: pointer wrap, registers cleared by reset
    begin_prog();
    poke(8'h00, 8'h31); poke(8'h01, 8'hFE);
    poke(8'h02, 8'h41); poke(8'h03, 8'h81);
    poke(8'h04, 8'h00); poke(8'h05, 8'h00);
    poke(8'hFE, 8'h51); poke(8'hFF, 8'h80);
    poke(8'h80, 8'h33);
    run_prog();
    chk(mem[8'h81] == 8'h33, "R2", "store after pointer wrap", mem[8'h81], 8'h33);
    chk(mem_addr == 8'h06, "R9", "halted address", mem_addr, 6);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog expired t=%0t", $time);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule